// File: doc/BRIEF.md
# Ripple-Slice Integer ALU with Status Flags

A purely combinational arithmetic-logic unit for two WIDTH-bit operands (32 by default). A 3-bit operation select chooses among bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Alongside the WIDTH-bit result it reports three flags:

- a zero flag;
- a signed overflow flag;
- the carry out of the top bit.

The datapath is a chain of identical one-bit slices, each built around a full adder. Every slice also carries a "less" input. The top slice is a variant that additionally produces the signed-overflow and "set" signals. The set signal loops back into the less input of bit 0 to form the set-on-less-than answer. Operation-select bit 2 inverts operand B in every slice and also forms the carry into bit 0, so subtraction is A + ~B + 1. The two low select bits steer a four-way multiplexer in each slice.

Top module: `alu_rs_top`

## Requirements
- R1: With op_sel = 3'b000, result equals the bitwise AND of op_a and op_b.
- R2: With op_sel = 3'b001, result equals the bitwise OR of op_a and op_b.
- R3: With op_sel = 3'b010, result equals (op_a + op_b) modulo 2^WIDTH, and carry_f is bit WIDTH of the unsigned sum. That bit indicates unsigned overflow.
- R4: With op_sel = 3'b110, result equals (op_a - op_b) modulo 2^WIDTH, formed as op_a + ~op_b + 1. carry_f is bit WIDTH of that sum, which is 1 exactly when op_a >= op_b unsigned.
- R5: zero_f is 1 exactly when every result bit is 0, for every listed operation.
- R6: For op_sel 3'b010 and 3'b110, ovf_f is 1 exactly when the signed result does not fit in WIDTH bits. For addition this means equal operand signs with a result sign that differs. For subtraction it means differing operand signs with a result sign that differs from op_a.
- R7: With op_sel = 3'b111, result bit 0 is 1 exactly when op_a < op_b as signed two's-complement numbers. This includes the cases where the difference overflows. All other result bits are 0.
- R8: With op_sel = 3'b111, carry_f and ovf_f equal the values the subtraction op_a - op_b would give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation select (000 AND, 001 OR, 010 ADD, 110 SUB, 111 set-less-than) |
| result | output | WIDTH | Operation result |
| zero_f | output | 1 | Result is all zeros |
| ovf_f | output | 1 | Signed overflow (carry into MSB xor carry out of MSB) |
| carry_f | output | 1 | Carry out of the most significant bit |

## Verification
Whenever the inputs change, immediate assertions check the bitwise AND result, the adder sum against a plain arithmetic sum, and the sign rule for addition overflow. They also check that set-on-less-than clears every bit above bit 0 and returns the signed comparison. The bench scenarios cover what those checks leave open: the zero flag across operations, subtraction borrow behaviour, and flag values under set-on-less-than. They also cover the overflow corner pairs such as the most negative value against positive operands, where the raw difference sign is wrong and must be corrected.

// File: rtl/alu_rs_pkg.sv
package alu_rs_pkg;
  localparam int unsigned ALU_W = 32;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // low select bits choose the slice output
  localparam logic [1:0] MUX_AND  = 2'b00;
  localparam logic [1:0] MUX_OR   = 2'b01;
  localparam logic [1:0] MUX_SUM  = 2'b10;
  localparam logic [1:0] MUX_LESS = 2'b11;
endpackage

// File: rtl/alu_rs_slice.sv
module alu_rs_slice
  import alu_rs_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       less_i,
  input  logic       cin_i,
  input  logic [2:0] sel_i,
  output logic       r_o,
  output logic       cout_o,
  output logic       sum_o
);
  logic b_eff;
  logic prop;

  always_comb begin
    b_eff  = b_i ^ sel_i[2];
    prop   = a_i ^ b_eff;
    sum_o  = prop ^ cin_i;
    cout_o = (a_i & b_eff) | (cin_i & prop);
    unique case (sel_i[1:0])
      MUX_AND: r_o = a_i & b_eff;
      MUX_OR:  r_o = a_i | b_eff;
      MUX_SUM: r_o = sum_o;
      default: r_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_rs_msb_slice.sv
module alu_rs_msb_slice
  import alu_rs_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       less_i,
  input  logic       cin_i,
  input  logic [2:0] sel_i,
  output logic       r_o,
  output logic       cout_o,
  output logic       ovf_o,
  output logic       set_o
);
  logic sum_w;

  alu_rs_slice u_core (
    .a_i    (a_i),
    .b_i    (b_i),
    .less_i (less_i),
    .cin_i  (cin_i),
    .sel_i  (sel_i),
    .r_o    (r_o),
    .cout_o (cout_o),
    .sum_o  (sum_w)
  );

  // overflow flips the raw sign to give the true less-than answer
  always_comb begin
    ovf_o = cin_i ^ cout_o;
    set_o = sum_w ^ ovf_o;
  end
endmodule

// File: rtl/alu_rs_top.sv
module alu_rs_top
  import alu_rs_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero_f,
  output logic             ovf_f,
  output logic             carry_f
);
  localparam int unsigned MSB = WIDTH - 1;

  logic set_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic cin;
    logic co;
    logic r;
    if (i == 0) begin : g_first
      assign cin = op_sel[2];
    end else begin : g_rest
      assign cin = g_bit[i-1].co;
    end

    if (i == MSB) begin : g_msb
      alu_rs_msb_slice u_slice (
        .a_i    (op_a[i]),
        .b_i    (op_b[i]),
        .less_i (1'b0),
        .cin_i  (cin),
        .sel_i  (op_sel),
        .r_o    (r),
        .cout_o (co),
        .ovf_o  (ovf_f),
        .set_o  (set_w)
      );
    end else begin : g_plain
      logic sum_unused;
      logic less;
      if (i == 0) begin : g_lsb
        assign less = set_w;
      end else begin : g_zero
        assign less = 1'b0;
      end
      alu_rs_slice u_slice (
        .a_i    (op_a[i]),
        .b_i    (op_b[i]),
        .less_i (less),
        .cin_i  (cin),
        .sel_i  (op_sel),
        .r_o    (r),
        .cout_o (co),
        .sum_o  (sum_unused)
      );
    end
    assign result[i] = r;
  end

  assign carry_f = g_bit[MSB].co;
  assign zero_f  = ~(|result);

  // cross-checks of the slice chain against plain arithmetic
  logic [WIDTH:0] chk_sum;
  always_comb begin
    chk_sum = {1'b0, op_a} + {1'b0, op_b};
    if (!$isunknown({op_a, op_b, op_sel})) begin
      if (op_sel == OP_AND)
        a_r1_and_bits: assert (result == (op_a & op_b));
      if (op_sel == OP_ADD) begin
        a_r3_add_sum: assert ({carry_f, result} == chk_sum);
        a_r6_add_overflow: assert (ovf_f ==
          ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])));
      end
      if (op_sel == OP_SLT) begin
        a_r7_slt_upper_zero: assert (result[MSB:1] == '0);
        a_r7_slt_value: assert (result[0] == ($signed(op_a) < $signed(op_b)));
      end
    end
  end
endmodule

// File: tb/tb_alu_rs_top.sv
module tb_alu_rs_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [2:0]   op_sel = 3'b000;
  logic [W-1:0] result;
  logic zero_f, ovf_f, carry_f;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_rs_top #(.WIDTH(W)) dut (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(result), .zero_f(zero_f), .ovf_f(ovf_f), .carry_f(carry_f)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h op=%b actual=%h expected=%h",
               tag, op_a, op_b, op_sel, got, exp);
    end
  endtask

  // behavioural reference, compared half a clock after each drive
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic v;
    @(posedge clk);
    op_a = a; op_b = b; op_sel = op;
    @(negedge clk);
    if (op == 3'b000) begin
      chk("R1 and", result, a & b);
      chk("R5 zero", zero_f, ((a & b) == 0));
    end else if (op == 3'b001) begin
      chk("R2 or", result, a | b);
      chk("R5 zero", zero_f, ((a | b) == 0));
    end else if (op == 3'b010) begin
      s = {1'b0, a} + {1'b0, b};
      r = s[W-1:0];
      v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      chk("R3 sum", result, r);
      chk("R3 carry", carry_f, s[W]);
      chk("R6 add ovf", ovf_f, v);
      chk("R5 zero", zero_f, (r == 0));
    end else begin
      s = {1'b0, a} - {1'b0, b};
      r = s[W-1:0];
      v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      if (op == 3'b110) begin
        chk("R4 diff", result, r);
        chk("R4 carry", carry_f, (a >= b));
        chk("R6 sub ovf", ovf_f, v);
        chk("R5 zero", zero_f, (r == 0));
      end else begin
        chk("R7 slt", result, {{(W-1){1'b0}}, ($signed(a) < $signed(b))});
        chk("R8 slt carry", carry_f, (a >= b));
        chk("R8 slt ovf", ovf_f, v);
        chk("R5 zero", zero_f, !($signed(a) < $signed(b)));
      end
    end
  endtask

  task automatic all_ops(logic [W-1:0] a, logic [W-1:0] b);
    apply(a, b, 3'b000);
    apply(a, b, 3'b001);
    apply(a, b, 3'b010);
    apply(a, b, 3'b110);
    apply(a, b, 3'b111);
  endtask

  initial begin
    logic [W-1:0] corner [8];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h8000_0001;
    corner[6] = 32'hAAAA_5555; corner[7] = 32'h0000_0005;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: zero operands under AND
    chk("R1 idle result", result, '0);
    chk("R5 idle zero", zero_f, 1'b1);
    // corner pairs, including SLT overflow cases (R7)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        all_ops(corner[i], corner[j]);
    // equal operands give zero difference (R4, R5)
    all_ops(32'h1234_5678, 32'h1234_5678);
    for (int k = 0; k < 2000; k++)
      all_ops($urandom, $urandom);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule